// File: doc/BRIEF.md
# Leveled Maskable Interrupt Arbiter

This block gathers requests from a parameterised set of maskable interrupt sources (eight by default) and tells the CPU which one, if any, it should take. Each source has a sticky pending flag and a small priority level, where level zero turns the source off. A master enable and a processor threshold gate the whole set. A source is eligible when the master enable is on, its flag is pending and its level is strictly above the threshold. Among the eligible sources the highest level wins, and the lowest index breaks a tie.

The winner is presented on a registered valid/index pair that is recomputed every clock. When the CPU pulses the acknowledge while valid is high, the flag of the presented source is cleared. A small write port sets the enable, the threshold and the per-source levels, and clears pending flags. Software can never set a flag. A combinational read port returns every piece of state.

Register addresses: 0 holds the master enable in bit 0, 1 holds the threshold in bits 2:0, 2 holds the pending flags (bit k for source k), and 4+k holds the level of source k in bits 2:0. Other addresses read as zero and ignore writes.

Top module: `irq_level_arb`

## Requirements
- R1: After reset, irq_valid and irq_idx are 0, and every readable register (enable, threshold, flags, all levels) reads 0.
- R2: A source whose src_req bit is 1 at a clock edge has its flag (bit k of address 2) set to 1 after that edge.
- R3: An ack at an edge while irq_valid is 1 clears the flag of the source given by irq_idx, and only that flag.
- R4: A write to address 2 clears each flag whose data bit is 0. A flag whose data bit is 1 keeps its value.
- R5: While the master enable (address 0, bit 0) is 0, irq_valid is 0 whatever flags are pending.
- R6: A pending source is eligible only when its level is strictly greater than the threshold. Level 0 is never eligible, and threshold 7 blocks every source.
- R7: Among eligible sources, irq_idx names the one with the highest level. On equal levels the lower index wins.
- R8: A write to any one register address leaves every other register unchanged.
- R9: irq_valid and irq_idx are registered. After each edge they reflect the enable, threshold, levels and flags produced by that same edge.
- R10: If src_req for a source is 1 at the same edge that an ack or a software write would clear its flag, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Per-source request, sets the pending flag |
| ack | input | 1 | CPU has taken the vector of the presented source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq_valid | output | 1 | An eligible request is being presented |
| irq_idx | output | IDX_W | Index of the winning source |

## Verification
The hardest case to reach from the ports is a collision at one edge: a fresh request arrives for exactly the source that an acknowledge or a software clear is removing. The acknowledge only names the source held in the output register. The bench therefore first steers a chosen source to the winning position through levels and threshold, and then raises that source's request in the same cycle as the acknowledge. A second directed case does the same against a software clear. A long run of random stimulus then replays enables, thresholds, levels, acknowledges and clears against a reference model of the requirements, which also covers ties and threshold edges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // register map; addresses fixed so software and bench agree
   localparam int unsigned REG_EN       = 0;
   localparam int unsigned REG_THR      = 1;
   localparam int unsigned REG_FLG      = 2;
   localparam int unsigned REG_LVL_BASE = 4;
endpackage

// File: rtl/irq_arb_cfg.sv
module irq_arb_cfg
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [LVL_W-1:0]             wr_val,
   output logic                         en_q,
   output logic [LVL_W-1:0]             thr_q,
   output logic [N_SRC-1:0][LVL_W-1:0]  lvl_q,
   output logic                         en_d,
   output logic [LVL_W-1:0]             thr_d,
   output logic [N_SRC-1:0][LVL_W-1:0]  lvl_d
);

   always_comb begin
      en_d  = en_q;
      thr_d = thr_q;
      if (wr_en && wr_addr == ADDR_W'(REG_EN))  en_d  = wr_val[0];
      if (wr_en && wr_addr == ADDR_W'(REG_THR)) thr_d = wr_val;
   end

   for (genvar k = 0; k < N_SRC; k++) begin : g_lvl
      always_comb begin
         lvl_d[k] = lvl_q[k];
         if (wr_en && wr_addr == ADDR_W'(REG_LVL_BASE + k)) lvl_d[k] = wr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         thr_q <= '0;
         lvl_q <= '0;
      end else begin
         en_q  <= en_d;
         thr_q <= thr_d;
         lvl_q <= lvl_d;
      end
   end

   // R8
   thr_wr_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(REG_THR)) |=> $stable(en_q));
   // R8
   en_wr_keeps_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(REG_EN)) |=> $stable(thr_q) && $stable(lvl_q));

endmodule

// File: rtl/irq_arb_flags.sv
module irq_arb_flags #(
   parameter int unsigned N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_req,
   input  logic [N_SRC-1:0] ack_clr,
   input  logic             sw_clr_en,
   input  logic [N_SRC-1:0] sw_keep,
   output logic [N_SRC-1:0] flag_q,
   output logic [N_SRC-1:0] flag_d
);

   logic [N_SRC-1:0] sw_clr;

   assign sw_clr = sw_clr_en ? ~sw_keep : '0;
   // a new request outranks any clear in the same cycle
   assign flag_d = src_req | (flag_q & ~ack_clr & ~sw_clr);

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag_d;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_chk
      // R10
      req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         src_req[i] |=> flag_q[i]);
      // R4
      sw_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_clr_en && sw_keep[i] && !ack_clr[i] && !src_req[i]) |=> flag_q[i] == $past(flag_q[i]));
      // R3
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_clr[i] && !src_req[i]) |=> !flag_q[i]);
   end

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned IDX_W = 3
) (
   input  logic                         en,
   input  logic [LVL_W-1:0]             thr,
   input  logic [N_SRC-1:0][LVL_W-1:0]  lvl,
   input  logic [N_SRC-1:0]             flag,
   output logic                         hit,
   output logic [IDX_W-1:0]             idx
);

   logic [N_SRC:0]                 found;
   logic [N_SRC:0][LVL_W-1:0]      best_lvl;
   logic [N_SRC:0][IDX_W-1:0]      best_idx;

   assign found[0]    = 1'b0;
   assign best_lvl[0] = '0;
   assign best_idx[0] = '0;

   // linear scan from index 0 upward: only a strictly higher level replaces
   // the running winner, so ties keep the lower index
   for (genvar i = 0; i < N_SRC; i++) begin : g_scan
      logic elig, take;
      assign elig = en && flag[i] && (lvl[i] > thr);
      assign take = elig && (!found[i] || lvl[i] > best_lvl[i]);
      assign found[i+1]    = found[i] | elig;
      assign best_lvl[i+1] = take ? lvl[i]       : best_lvl[i];
      assign best_idx[i+1] = take ? IDX_W'(i)    : best_idx[i];
   end

   assign hit = found[N_SRC];
   assign idx = best_idx[N_SRC];

endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
   import irq_arb_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req,
   input  logic              ack,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_valid,
   output logic [IDX_W-1:0]  irq_idx
);

   localparam logic [LVL_W-1:0] THR_MAX = '1;

   if (DATA_W < N_SRC || DATA_W < LVL_W) begin : g_bad_data_w
      $error("DATA_W must hold the flag vector and a level");
   end
   if (REG_LVL_BASE + N_SRC > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ADDR_W too small for the level registers");
   end
   if (LVL_W < 1 || N_SRC < 1) begin : g_bad_size
      $error("LVL_W and N_SRC must be at least 1");
   end

   logic                        en_q, en_d;
   logic [LVL_W-1:0]            thr_q, thr_d;
   logic [N_SRC-1:0][LVL_W-1:0] lvl_q, lvl_d;
   logic [N_SRC-1:0]            flag_q, flag_d, ack_clr;
   logic                        sw_clr_en, pick_hit;
   logic [IDX_W-1:0]            pick_idx;

   irq_arb_cfg #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_val(wr_data[LVL_W-1:0]),
      .en_q(en_q), .thr_q(thr_q), .lvl_q(lvl_q),
      .en_d(en_d), .thr_d(thr_d), .lvl_d(lvl_d)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_ack
      assign ack_clr[i] = ack && irq_valid && (irq_idx == IDX_W'(i));
   end

   assign sw_clr_en = wr_en && (wr_addr == ADDR_W'(REG_FLG));

   irq_arb_flags #(.N_SRC(N_SRC)) flags_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack_clr(ack_clr),
      .sw_clr_en(sw_clr_en), .sw_keep(wr_data[N_SRC-1:0]),
      .flag_q(flag_q), .flag_d(flag_d)
   );

   // arbitration looks at next-state values so the output register
   // tracks the state written by the same edge
   irq_arb_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) pick_i (
      .en(en_d), .thr(thr_d), .lvl(lvl_d), .flag(flag_d),
      .hit(pick_hit), .idx(pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_idx   <= '0;
      end else begin
         irq_valid <= pick_hit;
         irq_idx   <= pick_idx;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_EN))  rd_data = DATA_W'(en_q);
      if (rd_addr == ADDR_W'(REG_THR)) rd_data = DATA_W'(thr_q);
      if (rd_addr == ADDR_W'(REG_FLG)) rd_data = DATA_W'(flag_q);
      for (int k = 0; k < N_SRC; k++) begin
         if (rd_addr == ADDR_W'(REG_LVL_BASE + k)) rd_data = DATA_W'(lvl_q[k]);
      end
   end

   // R5
   valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> en_q);
   // R3
   valid_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> flag_q[irq_idx]);
   // R6
   valid_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> lvl_q[irq_idx] > thr_q);
   // R6
   thr_max_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q == THR_MAX) |-> !irq_valid);

   for (genvar j = 0; j < N_SRC; j++) begin : g_win_chk
      // R7
      winner_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q && flag_q[j] && lvl_q[j] > thr_q) |->
            irq_valid && ((lvl_q[j] < lvl_q[irq_idx]) ||
                          (lvl_q[j] == lvl_q[irq_idx] && irq_idx <= IDX_W'(j))));
   end

endmodule

// File: tb/irq_level_arb_tb_top.sv
module irq_level_arb_tb_top;

   typedef struct {
      logic       valid;
      logic [2:0] idx;
      logic [7:0] flags;
      string      tag;
   } sb_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_req = '0;
   logic       ack = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = 4'd2;
   logic [7:0] rd_data;
   logic       irq_valid;
   logic [2:0] irq_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   sb_item_t sb[$];

   logic       m_en;
   logic [2:0] m_thr;
   logic [2:0] m_lvl [8];
   logic [7:0] m_flag;
   logic       m_valid;
   logic [2:0] m_idx;

   always #4 clk = ~clk;

   irq_level_arb dut_i (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack(ack),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_valid(irq_valid), .irq_idx(irq_idx)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_eval();
      logic [2:0] best;
      best = '0;
      m_valid = 1'b0;
      m_idx = '0;
      for (int i = 0; i < 8; i++) begin
         if (m_en && m_flag[i] && m_lvl[i] > m_thr && (!m_valid || m_lvl[i] > best)) begin
            m_valid = 1'b1;
            best = m_lvl[i];
            m_idx = 3'(i);
         end
      end
   endtask

   // driver: apply one cycle of stimulus at a falling edge, update the
   // model, push the expected result for the coming rising edge
   task automatic step(input logic [7:0] req, input logic ack_i, input logic we,
                       input logic [3:0] addr, input logic [7:0] data, input string tag);
      logic [7:0] clr;
      sb_item_t it;
      src_req = req; ack = ack_i; wr_en = we; wr_addr = addr; wr_data = data;
      clr = '0;
      if (ack_i && m_valid) clr[m_idx] = 1'b1;
      if (we && addr == 4'd2) clr = clr | ~data;
      m_flag = req | (m_flag & ~clr);
      if (we) begin
         if (addr == 4'd0) m_en = data[0];
         if (addr == 4'd1) m_thr = data[2:0];
         if (addr >= 4'd4 && addr <= 4'd11) m_lvl[addr - 4'd4] = data[2:0];
      end
      model_eval();
      it.valid = m_valid; it.idx = m_idx; it.flags = m_flag; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      src_req = '0; ack = 1'b0; wr_en = 1'b0;
   endtask

   task automatic idle(input string tag);
      step(8'h00, 1'b0, 1'b0, 4'd0, 8'h00, tag);
   endtask

   task automatic rd_chk(input logic [3:0] a, input int exp, input string tag);
      rd_addr = a;
      #1;
      chk(tag, int'(rd_data), exp);
      rd_addr = 4'd2;
   endtask

   // monitor: compare after each rising edge, well clear of it
   initial begin
      sb_item_t it;
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            chk({it.tag, " valid"}, int'(irq_valid), int'(it.valid));
            chk({it.tag, " idx"},   int'(irq_idx),   int'(it.idx));
            chk({it.tag, " flags"}, int'(rd_data),   int'(it.flags));
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_en = 1'b0; m_thr = '0; m_flag = '0; m_valid = 1'b0; m_idx = '0;
      for (int i = 0; i < 8; i++) m_lvl[i] = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_valid", int'(irq_valid), 0);
      chk("R1 irq_idx", int'(irq_idx), 0);
      for (int a = 0; a < 12; a++) rd_chk(4'(a), 0, "R1 register");

      // configuration: levels 3,5,5,0,1,2,4,7
      step(8'h00, 1'b0, 1'b1, 4'd4,  8'd3, "R8 lvl0");
      step(8'h00, 1'b0, 1'b1, 4'd5,  8'd5, "R8 lvl1");
      step(8'h00, 1'b0, 1'b1, 4'd6,  8'd5, "R8 lvl2");
      step(8'h00, 1'b0, 1'b1, 4'd8,  8'd1, "R8 lvl4");
      step(8'h00, 1'b0, 1'b1, 4'd9,  8'd2, "R8 lvl5");
      step(8'h00, 1'b0, 1'b1, 4'd10, 8'd4, "R8 lvl6");
      step(8'h00, 1'b0, 1'b1, 4'd11, 8'd7, "R8 lvl7");
      step(8'h00, 1'b0, 1'b1, 4'd0,  8'd1, "R8 enable");
      rd_chk(4'd5, 5, "R8 lvl1 readback");
      rd_chk(4'd1, 0, "R8 thr after enable write");

      // R6 level 0 source never eligible, R2 its flag still set
      step(8'h08, 1'b0, 1'b0, 4'd0, 8'h00, "R6 level zero");
      // R2 / R9 single request presented on the same edge
      step(8'h01, 1'b0, 1'b0, 4'd0, 8'h00, "R9 src0");
      // R7 tie between 1 and 2 at level 5 -> 1
      step(8'h06, 1'b0, 1'b0, 4'd0, 8'h00, "R7 tie");
      chk("R7 tie idx", int'(irq_idx), 1);
      // R3 ack clears 1, then 2 wins
      step(8'h00, 1'b1, 1'b0, 4'd0, 8'h00, "R3 ack");
      chk("R3 after ack idx", int'(irq_idx), 2);
      // R6 threshold 5: level 5 not above
      step(8'h00, 1'b0, 1'b1, 4'd1, 8'd5, "R6 thr5");
      chk("R6 thr5 valid", int'(irq_valid), 0);
      step(8'h00, 1'b0, 1'b1, 4'd1, 8'd4, "R6 thr4");
      chk("R6 thr4 idx", int'(irq_idx), 2);
      // R5 enable off
      step(8'h00, 1'b0, 1'b1, 4'd0, 8'd0, "R5 disable");
      chk("R5 disabled valid", int'(irq_valid), 0);
      rd_chk(4'd1, 4, "R8 thr kept");
      step(8'h00, 1'b0, 1'b1, 4'd0, 8'd1, "R5 enable");
      // R4 writing ones leaves flags, zero bit clears
      step(8'h00, 1'b0, 1'b1, 4'd2, 8'hFF, "R4 write ones");
      rd_chk(4'd2, 8'h0D, "R4 flags kept");
      step(8'h00, 1'b0, 1'b1, 4'd2, 8'hFB, "R4 clear bit2");
      rd_chk(4'd2, 8'h09, "R4 flag2 cleared");
      // R6 threshold 7 blocks level 7
      step(8'h00, 1'b0, 1'b1, 4'd1, 8'd7, "R6 thr7");
      step(8'h80, 1'b0, 1'b0, 4'd0, 8'h00, "R6 thr7 src7");
      chk("R6 thr7 valid", int'(irq_valid), 0);
      step(8'h00, 1'b0, 1'b1, 4'd1, 8'd6, "R6 thr6");
      chk("R6 thr6 idx", int'(irq_idx), 7);
      // R10 request collides with ack of the same source
      step(8'h80, 1'b1, 1'b0, 4'd0, 8'h00, "R10 ack collide");
      chk("R10 ack collide idx", int'(irq_idx), 7);
      // R10 request collides with software clear
      step(8'h01, 1'b0, 1'b1, 4'd2, 8'h00, "R10 sw collide");
      rd_chk(4'd2, 8'h01, "R10 sw collide flags");
      step(8'h00, 1'b0, 1'b1, 4'd1, 8'd0, "R7 thr0");
      chk("R7 thr0 idx", int'(irq_idx), 0);

      // random replay against the model
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] rq, dt;
         logic [3:0] ad;
         logic we;
         rq = 8'($urandom) & 8'($urandom) & 8'($urandom);
         we = ($urandom % 3) == 0;
         case ($urandom % 6)
            0: ad = 4'd0;
            1: ad = 4'd1;
            2: ad = 4'd2;
            default: ad = 4'(4 + ($urandom % 8));
         endcase
         dt = 8'($urandom);
         if (ad == 4'd0) dt[0] = ($urandom % 5) != 0;
         if (ad == 4'd1) dt[2:0] = 3'($urandom % 8) & 3'($urandom % 8);
         if (ad == 4'd2) dt = dt | 8'($urandom);
         step(rq, ($urandom % 3) == 0, we, ad, dt, "R7 random");
      end
      idle("R9 drain");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule